// File: doc/BRIEF.md
# Mode-Banked Processor Register File

This block is the architectural register file of a small 32-bit processor that runs in one of four operating modes. It offers two combinational read ports and one synchronous write port, each addressed by a 4-bit logical register index. The active mode decides which physical copy a logical index reaches. Indices 0 to 7 always reach one common set. Indices 8 to 12 have a private copy that only the fast-interrupt mode uses. Indices 13 and 14 have a private copy in every mode. Index 15 is the program counter.

The program counter is kept as a 24-bit word address and is presented as a 32-bit byte address. It can be loaded through the write port or stepped by one word through an increment strobe. A status word combines the four condition flags, the two interrupt masks and the mode field. A whole status word is written through a dedicated strobe.

A debug override input can replace the stored mode for bank selection, on both the read ports and the write port. A test environment can use it to reach any banked copy directly without changing the stored mode.

Top module: `banked_regfile`

## Requirements
- R1: A synchronous reset (rst high at a rising edge) sets every physical register, the program counter, the flags and the mode to zero, and sets both interrupt masks. The status word therefore reads 0x0C000000.
- R2: Indices 0 to 7 reach one physical set. A value written in any mode reads back identically in every mode.
- R3: Indices 8 to 12 reach a private copy only when the effective mode is fast interrupt (code 1). User (0), interrupt (2) and supervisor (3) all reach the user copy.
- R4: Indices 13 and 14 each have four copies, one per mode code 0 to 3. The effective mode selects the copy.
- R5: Reads are combinational. A write takes effect at the rising edge while wr_en is high, and a read of the same register during that cycle returns the old value.
- R6: A read of index 15 returns {6'b0, pc, 2'b00}, which equals pc_addr.
- R7: A write to index 15 loads wr_data[25:2] into the program counter and takes priority over pc_inc in the same cycle.
- R8: pc_inc with no program-counter write adds one word (4 to the byte address), wrapping modulo 2^24 words. With neither input, the program counter holds.
- R9: status_word holds N,Z,C,V in bits 31 to 28, the interrupt mask in bit 27, the fast-interrupt mask in bit 26 and the mode in bits 1:0. All other bits read zero. A high status_we loads these fields from status_wdata at the rising edge.
- R10: When dbg_mode_en is high, dbg_mode replaces the stored mode for bank selection on both read ports and the write port. The stored mode shown in status_word is left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| dbg_mode_en | input | 1 | Use dbg_mode instead of the stored mode for bank selection |
| dbg_mode | input | 2 | Override mode code |
| rd_a_idx | input | 4 | Read port A register index |
| rd_a_data | output | 32 | Read port A data |
| rd_b_idx | input | 4 | Read port B register index |
| rd_b_data | output | 32 | Read port B data |
| wr_en | input | 1 | Write strobe |
| wr_idx | input | 4 | Write register index |
| wr_data | input | 32 | Write data |
| pc_inc | input | 1 | Advance the program counter by one word |
| pc_addr | output | 32 | Program counter as a byte address |
| status_we | input | 1 | Load the status fields |
| status_wdata | input | 32 | New status word, same layout as status_word |
| status_word | output | 32 | Composed status word |

## Verification
The bench builds the block with its default parameters: 32-bit data, a 24-bit word program counter, 4-bit indices, eight shared registers, five fast-interrupt copies and two per-mode registers. With these values the program counter wrap lies one increment away from a write of all ones, so the wrap can be checked directly. The 26 physical registers are few enough that every mode and index pair of the banked range gets a distinct value, and any aliasing between copies then shows up as a wrong readback.

// File: rtl/regfile_pkg.sv
package regfile_pkg;

    typedef enum logic [1:0] {
        MODE_USR = 2'd0,
        MODE_FIQ = 2'd1,
        MODE_IRQ = 2'd2,
        MODE_SVC = 2'd3
    } cpu_mode_e;

    localparam int MODE_W   = 2;
    localparam int MODE_N   = 4;
    localparam int FLAG_W   = 4;

    // status word bit positions
    localparam int ST_FLAG_HI = 31;
    localparam int ST_FLAG_LO = 28;
    localparam int ST_IRQ_BIT = 27;
    localparam int ST_FIQ_BIT = 26;
    localparam int ST_MODE_LO = 0;

endpackage

// File: rtl/regfile_slot_map.sv
module regfile_slot_map
    import regfile_pkg::*;
#(
    parameter int IDX_W     = 4,
    parameter int SHARED_N  = 8,
    parameter int FIQBANK_N = 5,
    parameter int PERMODE_N = 2,
    parameter int SLOT_W    = 5
) (
    input  logic [IDX_W-1:0]  idx,
    input  cpu_mode_e         mode,
    output logic [SLOT_W-1:0] slot,
    output logic              is_pc
);
    localparam int FIQ_FIRST   = SHARED_N;
    localparam int MODE_FIRST  = SHARED_N + FIQBANK_N;
    localparam int PC_IDX      = MODE_FIRST + PERMODE_N;
    localparam int USRHI_BASE  = SHARED_N;
    localparam int FIQHI_BASE  = SHARED_N + FIQBANK_N;
    localparam int MODEB_BASE  = SHARED_N + 2 * FIQBANK_N;

    int unsigned idx_i;
    int unsigned mode_i;
    int unsigned slot_i;

    always_comb begin
        idx_i  = 32'(idx);
        mode_i = 32'(mode);
        is_pc  = (idx_i == PC_IDX);
        if (idx_i < FIQ_FIRST) begin
            slot_i = idx_i;
        end else if (idx_i < MODE_FIRST) begin
            slot_i = (mode == MODE_FIQ) ? FIQHI_BASE + (idx_i - FIQ_FIRST)
                                        : USRHI_BASE + (idx_i - FIQ_FIRST);
        end else if (idx_i < PC_IDX) begin
            slot_i = MODEB_BASE + mode_i * PERMODE_N + (idx_i - MODE_FIRST);
        end else begin
            slot_i = 0;
        end
        slot = SLOT_W'(slot_i);
    end

endmodule

// File: rtl/regfile_pc_next.sv
module regfile_pc_next #(
    parameter int DATA_W = 32,
    parameter int PC_W   = 24
) (
    input  logic [PC_W-1:0]   pc_q,
    input  logic              load,
    input  logic [DATA_W-1:0] load_data,
    input  logic              step,
    output logic [PC_W-1:0]   pc_d,
    output logic [DATA_W-1:0] pc_bytes
);
    localparam int PAD_W = DATA_W - PC_W - 2;

    always_comb begin
        if (load) begin
            pc_d = load_data[PC_W+1:2];
        end else if (step) begin
            pc_d = pc_q + PC_W'(1);
        end else begin
            pc_d = pc_q;
        end
        pc_bytes = {{PAD_W{1'b0}}, pc_q, 2'b00};
    end

endmodule

// File: rtl/regfile_status_word.sv
module regfile_status_word
    import regfile_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [FLAG_W-1:0] flags,
    input  logic              irq_mask,
    input  logic              fiq_mask,
    input  cpu_mode_e         mode,
    output logic [DATA_W-1:0] word
);
    always_comb begin
        word = '0;
        word[ST_FLAG_HI:ST_FLAG_LO]        = flags;
        word[ST_IRQ_BIT]                   = irq_mask;
        word[ST_FIQ_BIT]                   = fiq_mask;
        word[ST_MODE_LO+MODE_W-1:ST_MODE_LO] = mode;
    end

endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
    import regfile_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int IDX_W     = 4,
    parameter int PC_W      = 24,
    parameter int SHARED_N  = 8,
    parameter int FIQBANK_N = 5,
    parameter int PERMODE_N = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              dbg_mode_en,
    input  logic [1:0]        dbg_mode,
    input  logic [IDX_W-1:0]  rd_a_idx,
    output logic [DATA_W-1:0] rd_a_data,
    input  logic [IDX_W-1:0]  rd_b_idx,
    output logic [DATA_W-1:0] rd_b_data,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              pc_inc,
    output logic [DATA_W-1:0] pc_addr,
    input  logic              status_we,
    input  logic [DATA_W-1:0] status_wdata,
    output logic [DATA_W-1:0] status_word
);
    localparam int PHYS_N = SHARED_N + 2 * FIQBANK_N + MODE_N * PERMODE_N;
    localparam int SLOT_W = $clog2(PHYS_N);
    localparam int PORT_N = 3;   // two readers, one writer

    typedef struct packed {
        logic [PHYS_N-1:0][DATA_W-1:0] regs;
        logic [PC_W-1:0]               pc;
        logic [FLAG_W-1:0]             flags;
        logic                          irq_mask;
        logic                          fiq_mask;
        cpu_mode_e                     mode;
    } rf_state_t;

    rf_state_t st_d, st_q;

    cpu_mode_e                        eff_mode;
    logic [PORT_N-1:0][IDX_W-1:0]     port_idx;
    logic [PORT_N-1:0][SLOT_W-1:0]    port_slot;
    logic [PORT_N-1:0]                port_pc;
    logic [PC_W-1:0]                  pc_next;
    logic [DATA_W-1:0]                pc_bytes;
    logic                             wr_pc;

    assign eff_mode = dbg_mode_en ? cpu_mode_e'(dbg_mode) : st_q.mode;
    assign port_idx = {wr_idx, rd_b_idx, rd_a_idx};

    for (genvar p = 0; p < PORT_N; p++) begin : g_map
        regfile_slot_map #(
            .IDX_W     (IDX_W),
            .SHARED_N  (SHARED_N),
            .FIQBANK_N (FIQBANK_N),
            .PERMODE_N (PERMODE_N),
            .SLOT_W    (SLOT_W)
        ) i_map (
            .idx   (port_idx[p]),
            .mode  (eff_mode),
            .slot  (port_slot[p]),
            .is_pc (port_pc[p])
        );
    end

    assign wr_pc = wr_en && port_pc[2];

    regfile_pc_next #(
        .DATA_W (DATA_W),
        .PC_W   (PC_W)
    ) i_pc (
        .pc_q      (st_q.pc),
        .load      (wr_pc),
        .load_data (wr_data),
        .step      (pc_inc),
        .pc_d      (pc_next),
        .pc_bytes  (pc_bytes)
    );

    regfile_status_word #(
        .DATA_W (DATA_W)
    ) i_status (
        .flags    (st_q.flags),
        .irq_mask (st_q.irq_mask),
        .fiq_mask (st_q.fiq_mask),
        .mode     (st_q.mode),
        .word     (status_word)
    );

    always_comb begin
        st_d    = st_q;
        st_d.pc = pc_next;
        if (wr_en && !port_pc[2]) begin
            st_d.regs[port_slot[2]] = wr_data;
        end
        if (status_we) begin
            st_d.flags    = status_wdata[ST_FLAG_HI:ST_FLAG_LO];
            st_d.irq_mask = status_wdata[ST_IRQ_BIT];
            st_d.fiq_mask = status_wdata[ST_FIQ_BIT];
            st_d.mode     = cpu_mode_e'(status_wdata[ST_MODE_LO+MODE_W-1:ST_MODE_LO]);
        end
        if (rst) begin
            st_d          = '0;
            st_d.irq_mask = 1'b1;
            st_d.fiq_mask = 1'b1;
            st_d.mode     = MODE_USR;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign rd_a_data = port_pc[0] ? pc_bytes : st_q.regs[port_slot[0]];
    assign rd_b_data = port_pc[1] ? pc_bytes : st_q.regs[port_slot[1]];
    assign pc_addr   = pc_bytes;

endmodule

// File: rtl/banked_regfile_checker.sv
module banked_regfile_checker #(
    parameter int DATA_W = 32,
    parameter int IDX_W  = 4,
    parameter int PC_W   = 24
) (
    input logic              clk,
    input logic              rst,
    input logic              dbg_mode_en,
    input logic [IDX_W-1:0]  rd_a_idx,
    input logic [DATA_W-1:0] rd_a_data,
    input logic              wr_en,
    input logic [IDX_W-1:0]  wr_idx,
    input logic [DATA_W-1:0] wr_data,
    input logic              pc_inc,
    input logic [DATA_W-1:0] pc_addr,
    input logic              status_we,
    input logic [DATA_W-1:0] status_wdata,
    input logic [DATA_W-1:0] status_word
);
    localparam logic [IDX_W-1:0] PC_IDX = '1;
    localparam logic [DATA_W-1:0] ST_KEEP = 32'hFC00_0003;

    p_pc_load_r7: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_idx == PC_IDX) |=> (pc_addr[PC_W+1:2] == $past(wr_data[PC_W+1:2])));

    p_pc_step_r8: assert property (@(posedge clk) disable iff (rst)
        (!(wr_en && wr_idx == PC_IDX) && pc_inc) |=>
            (pc_addr[PC_W+1:2] == $past(pc_addr[PC_W+1:2]) + PC_W'(1)));

    p_pc_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (!(wr_en && wr_idx == PC_IDX) && !pc_inc) |=> $stable(pc_addr));

    p_pc_read_r6: assert property (@(posedge clk) disable iff (rst)
        (rd_a_idx == PC_IDX) |-> (rd_a_data == pc_addr));

    p_status_load_r9: assert property (@(posedge clk) disable iff (rst)
        status_we |=> (status_word == ($past(status_wdata) & ST_KEEP)));

    p_status_hold_r10: assert property (@(posedge clk) disable iff (rst)
        !status_we |=> $stable(status_word));

    p_write_visible_r5: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_idx != PC_IDX && !status_we && !dbg_mode_en) |=>
            (dbg_mode_en || rd_a_idx != $past(wr_idx) || rd_a_data == $past(wr_data)));

endmodule

bind banked_regfile banked_regfile_checker #(
    .DATA_W (DATA_W),
    .IDX_W  (IDX_W),
    .PC_W   (PC_W)
) i_checker (
    .clk          (clk),
    .rst          (rst),
    .dbg_mode_en  (dbg_mode_en),
    .rd_a_idx     (rd_a_idx),
    .rd_a_data    (rd_a_data),
    .wr_en        (wr_en),
    .wr_idx       (wr_idx),
    .wr_data      (wr_data),
    .pc_inc       (pc_inc),
    .pc_addr      (pc_addr),
    .status_we    (status_we),
    .status_wdata (status_wdata),
    .status_word  (status_word)
);

// File: tb/test_banked_regfile.sv
module test_banked_regfile;

    logic        clk = 1'b0;
    logic        rst;
    logic        dbg_mode_en;
    logic [1:0]  dbg_mode;
    logic [3:0]  rd_a_idx;
    logic [31:0] rd_a_data;
    logic [3:0]  rd_b_idx;
    logic [31:0] rd_b_data;
    logic        wr_en;
    logic [3:0]  wr_idx;
    logic [31:0] wr_data;
    logic        pc_inc;
    logic [31:0] pc_addr;
    logic        status_we;
    logic [31:0] status_wdata;
    logic [31:0] status_word;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;   // 250 MHz

    banked_regfile i_banked_regfile (
        .clk          (clk),
        .rst          (rst),
        .dbg_mode_en  (dbg_mode_en),
        .dbg_mode     (dbg_mode),
        .rd_a_idx     (rd_a_idx),
        .rd_a_data    (rd_a_data),
        .rd_b_idx     (rd_b_idx),
        .rd_b_data    (rd_b_data),
        .wr_en        (wr_en),
        .wr_idx       (wr_idx),
        .wr_data      (wr_data),
        .pc_inc       (pc_inc),
        .pc_addr      (pc_addr),
        .status_we    (status_we),
        .status_wdata (status_wdata),
        .status_word  (status_word)
    );

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic idle();
        wr_en = 1'b0; pc_inc = 1'b0; status_we = 1'b0;
    endtask

    // write one register through the bank of mode m (debug override)
    task automatic wr_reg(input logic [1:0] m, input logic [3:0] idx, input logic [31:0] d);
        @(negedge clk);
        dbg_mode_en = 1'b1; dbg_mode = m;
        wr_en = 1'b1; wr_idx = idx; wr_data = d;
        @(negedge clk);
        idle();
    endtask

    // read port A and B through bank of mode m
    task automatic rd_chk(input string tag, input logic [1:0] m, input logic [3:0] idx,
                          input logic [31:0] exp);
        @(negedge clk);
        dbg_mode_en = 1'b1; dbg_mode = m;
        rd_a_idx = idx; rd_b_idx = idx;
        #1;
        check(tag, rd_a_data, exp);
        check(tag, rd_b_data, exp);
    endtask

    task automatic set_status(input logic [31:0] w);
        @(negedge clk);
        status_we = 1'b1; status_wdata = w;
        @(negedge clk);
        idle();
    endtask

    task automatic t_reset();
        for (int m = 0; m < 4; m++) begin
            for (int i = 0; i < 15; i++) begin
                rd_chk("R1 reg clear", 2'(m), 4'(i), 32'h0);
            end
        end
        #1;
        check("R1 pc clear", pc_addr, 32'h0);
        check("R1 status reset", status_word, 32'h0C00_0000);
    endtask

    task automatic t_shared();
        wr_reg(2'd3, 4'd3, 32'hA5A5_0003);
        wr_reg(2'd1, 4'd7, 32'h7777_0007);
        for (int m = 0; m < 4; m++) begin
            rd_chk("R2 shared r3", 2'(m), 4'd3, 32'hA5A5_0003);
            rd_chk("R2 shared r7", 2'(m), 4'd7, 32'h7777_0007);
        end
    endtask

    task automatic t_fiq_bank();
        for (int i = 8; i < 13; i++) begin
            wr_reg(2'd0, 4'(i), 32'h1000_0000 + 32'(i));
            wr_reg(2'd1, 4'(i), 32'hF000_0000 + 32'(i));
        end
        for (int i = 8; i < 13; i++) begin
            rd_chk("R3 user copy", 2'd0, 4'(i), 32'h1000_0000 + 32'(i));
            rd_chk("R3 irq uses user copy", 2'd2, 4'(i), 32'h1000_0000 + 32'(i));
            rd_chk("R3 svc uses user copy", 2'd3, 4'(i), 32'h1000_0000 + 32'(i));
            rd_chk("R3 fiq copy", 2'd1, 4'(i), 32'hF000_0000 + 32'(i));
        end
    endtask

    task automatic t_per_mode();
        for (int m = 0; m < 4; m++) begin
            wr_reg(2'(m), 4'd13, 32'hD000_0000 + 32'(m));
            wr_reg(2'(m), 4'd14, 32'hE000_0000 + 32'(m));
        end
        for (int m = 0; m < 4; m++) begin
            rd_chk("R4 r13 per mode", 2'(m), 4'd13, 32'hD000_0000 + 32'(m));
            rd_chk("R4 r14 per mode", 2'(m), 4'd14, 32'hE000_0000 + 32'(m));
        end
    endtask

    task automatic t_timing();
        @(negedge clk);
        dbg_mode_en = 1'b0;
        rd_a_idx = 4'd5;
        wr_en = 1'b1; wr_idx = 4'd5; wr_data = 32'h5555_AAAA;
        #1;
        check("R5 old value before edge", rd_a_data, 32'h0);
        @(negedge clk);
        idle();
        #1;
        check("R5 new value after edge", rd_a_data, 32'h5555_AAAA);
    endtask

    task automatic t_pc();
        // R7: load from write data bits 25:2
        @(negedge clk);
        wr_en = 1'b1; wr_idx = 4'd15; wr_data = 32'hFFFF_FFFF;
        @(negedge clk);
        idle();
        rd_chk("R6 read index 15", 2'd0, 4'd15, 32'h03FF_FFFC);
        check("R7 pc load", pc_addr, 32'h03FF_FFFC);
        // R8: wrap
        @(negedge clk);
        pc_inc = 1'b1;
        @(negedge clk);
        idle();
        #1;
        check("R8 pc wrap", pc_addr, 32'h0);
        // R7: write beats increment
        @(negedge clk);
        wr_en = 1'b1; wr_idx = 4'd15; wr_data = 32'h0000_1003; pc_inc = 1'b1;
        @(negedge clk);
        idle();
        #1;
        check("R7 write over inc", pc_addr, 32'h0000_1000);
        // R8: three steps, then hold
        @(negedge clk);
        pc_inc = 1'b1;
        repeat (3) @(negedge clk);
        idle();
        #1;
        check("R8 three steps", pc_addr, 32'h0000_100C);
        @(negedge clk);
        #1;
        check("R8 hold", pc_addr, 32'h0000_100C);
    endtask

    task automatic t_status();
        set_status(32'hFFFF_FFFF);
        #1;
        check("R9 status fields", status_word, 32'hFC00_0003);
        set_status(32'h5000_0001);   // flags 0101, masks clear, mode fiq
        #1;
        check("R9 status load", status_word, 32'h5000_0001);
        // stored mode fiq, no override: r9 reaches fiq copy
        @(negedge clk);
        dbg_mode_en = 1'b0; rd_a_idx = 4'd9;
        #1;
        check("R3 stored fiq mode", rd_a_data, 32'hF000_0009);
        // override to user: user copy, stored mode untouched
        rd_chk("R10 override read", 2'd0, 4'd9, 32'h1000_0009);
        check("R10 mode unchanged", status_word, 32'h5000_0001);
        wr_reg(2'd2, 4'd13, 32'h1234_5678);
        rd_chk("R10 override write", 2'd2, 4'd13, 32'h1234_5678);
        rd_chk("R10 fiq r13 untouched", 2'd1, 4'd13, 32'hD000_0001);
        check("R10 mode kept", status_word, 32'h5000_0001);
    endtask

    initial begin : watchdog
        #400000;
        errors++; checks++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        rst = 1'b1; dbg_mode_en = 1'b0; dbg_mode = 2'd0;
        rd_a_idx = '0; rd_b_idx = '0; wr_idx = '0; wr_data = '0; status_wdata = '0;
        idle();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_shared();
        t_fiq_bank();
        t_per_mode();
        t_timing();
        t_pc();
        t_status();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule